// File: doc/BRIEF.md
# Fine-Grained Register Write Trap Checker

This block holds a 64-bit control word written by the hypervisor, in which each implemented field controls whether lower-privilege writes to one system register, or to one family of related registers, are redirected to the hypervisor level. Each write request carries the privilege level of the requester, whether the hypervisor level is present and enabled in the current security state, the two host-mode bits and a target selector. From these the block decides, in the same cycle and without registers, whether the write must trap. It reports a trap flag and a syndrome class code.

The fields are active-low: a field holding 0 arms its trap. Two groups of fields behave differently. One group traps writes from both level 0 and level 1, and is switched off while the host-mode pair is {1,1}. The other group traps writes from level 1 only and does not look at the host-mode pair. The target selector equals the bit position of the field that controls that target. A separate level output tells the zero-register logic when writes to its F0 bit must be dropped. Exception priority, detection of undefined registers and exception entry are handled outside this block.

Top module: `fgt_wtrap`

## Requirements
- R1: After reset the control word reads as all zeros, so every implemented trap is armed.
- R2: A control write stores only the implemented bits (mask 0x79FFBF). Bits 63:23, 18:17 and 6 always read as zero.
- R3: A trap is raised only when the control bit at position `wr_sel` is 0. A 1 at that position disables the trap.
- R4: Selectors 22, 21, 14, 13, 11, 10, 9, 8, 3 and 2 trap writes from level 0 and level 1, but only when `host_mode` is not 2'b11.
- R5: Selectors 20, 19, 16, 15, 12, 7, 5, 4, 1 and 0 trap writes from level 1 only, whatever the value of `host_mode`.
- R6: No trap is raised while `hyp_en` is 0.
- R7: Writes from level 2 or level 3 never trap.
- R8: `syndrome` is 6'h18 whenever `trap` is 1 and 0 otherwise. Both outputs are combinational in the cycle of the request.
- R9: Selectors 6, 17, 18 and 23 to 31 never trap.
- R10: `f0_ignore` is 1 exactly when `hyp_en` is 1, the level is 0 or 1, `host_mode` is not 2'b11 and control bit 2 is 0. It does not depend on `wr_req`.
- R11: No trap is raised while `wr_req` is 0.
- R12: A control write takes effect at the next clock edge. A request in the same cycle as the write is judged against the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 64 | Control word write data |
| ctl_rdata | output | 64 | Stored control word; reserved bits read as zero |
| wr_req | input | 1 | A lower-level system register write is attempted |
| wr_el | input | 2 | Privilege level of the requester (0 to 3) |
| hyp_en | input | 1 | Hypervisor level is implemented and enabled |
| host_mode | input | 2 | Host-mode bit pair; 2'b11 gates off the level-0 group |
| wr_sel | input | 5 | Target selector, equal to the controlling field's bit position |
| trap | output | 1 | The write must be redirected to the hypervisor |
| syndrome | output | 6 | Syndrome class code, 6'h18 on a trap |
| f0_ignore | output | 1 | Writes to the zero-register F0 bit must be dropped |

## Verification
A control-word update and a trap decision can happen in the same cycle. The bench provokes this by driving a write request while `ctl_we` carries a word that flips the armed state of the selected field. It expects the decision before the edge to follow the old word and the decision after the edge to follow the new one. Around that case, it sweeps every selector, level, host-mode value and enable under several control words. Each output is compared with a value computed from the two group lists.

// File: rtl/fgt_wtrap.sv
module fgt_wtrap #(
  parameter int WORD_W = 64,
  parameter int SEL_W = 5,
  parameter int SYN_W = 6,
  parameter logic [SYN_W-1:0] TRAP_CLASS = 6'h18,
  parameter logic [WORD_W-1:0] BOTH_MASK = 64'h0000_0000_0060_6F0C,
  parameter logic [WORD_W-1:0] EL1_MASK  = 64'h0000_0000_0019_90B3,
  parameter int F0_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [WORD_W-1:0] ctl_wdata,
  output logic [WORD_W-1:0] ctl_rdata,
  input  logic              wr_req,
  input  logic [1:0]        wr_el,
  input  logic              hyp_en,
  input  logic [1:0]        host_mode,
  input  logic [SEL_W-1:0]  wr_sel,
  output logic              trap,
  output logic [SYN_W-1:0]  syndrome,
  output logic              f0_ignore
);
  localparam logic [WORD_W-1:0] IMPL_MASK = BOTH_MASK | EL1_MASK;

  logic [WORD_W-1:0] ctl_q;
  logic low_el, host_gate, armed, hit_both, hit_el1;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_wdata & IMPL_MASK;
  end

  assign ctl_rdata = ctl_q;

  assign low_el    = (wr_el == 2'd0) || (wr_el == 2'd1);
  assign host_gate = (host_mode != 2'b11);
  assign armed     = IMPL_MASK[wr_sel] && !ctl_q[wr_sel];
  assign hit_both  = BOTH_MASK[wr_sel] && low_el && host_gate;
  assign hit_el1   = EL1_MASK[wr_sel] && (wr_el == 2'd1);

  assign trap      = wr_req && hyp_en && armed && (hit_both || hit_el1);
  assign syndrome  = trap ? TRAP_CLASS : '0;
  assign f0_ignore = hyp_en && low_el && host_gate && !ctl_q[F0_BIT];
endmodule

module fgt_wtrap_chk #(
  parameter int WORD_W = 64,
  parameter int SEL_W = 5,
  parameter int SYN_W = 6,
  parameter logic [WORD_W-1:0] IMPL = 64'h0000_0000_0079_FFBF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_we,
  input logic [WORD_W-1:0] ctl_wdata,
  input logic [WORD_W-1:0] ctl_rdata,
  input logic              wr_req,
  input logic [1:0]        wr_el,
  input logic              hyp_en,
  input logic [1:0]        host_mode,
  input logic [SEL_W-1:0]  wr_sel,
  input logic              trap,
  input logic [SYN_W-1:0]  syndrome
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata & ~IMPL) == '0);
  assert_write_lands_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_rdata == ($past(ctl_wdata) & IMPL));
  assert_hold_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_rdata));
  assert_active_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !ctl_rdata[wr_sel]);
  assert_needs_hyp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> hyp_en);
  assert_high_el_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> wr_el <= 2'd1);
  assert_el0_host_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && wr_el == 2'd0) |-> host_mode != 2'b11);
  assert_syndrome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    syndrome == (trap ? 6'h18 : 6'h00));
  assert_reserved_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> IMPL[wr_sel]);
  assert_req_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> wr_req);
endmodule

bind fgt_wtrap fgt_wtrap_chk #(.WORD_W(WORD_W), .SEL_W(SEL_W), .SYN_W(SYN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .wr_req(wr_req), .wr_el(wr_el), .hyp_en(hyp_en),
  .host_mode(host_mode), .wr_sel(wr_sel), .trap(trap), .syndrome(syndrome)
);

// File: tb/fgt_wtrap_bench.sv
module fgt_wtrap_bench;
  logic clk = 0, rst_n = 0, ctl_we = 0, wr_req = 0, hyp_en = 0;
  logic [63:0] ctl_wdata = '0, ctl_rdata;
  logic [1:0] wr_el = '0, host_mode = '0;
  logic [4:0] wr_sel = '0;
  logic trap, f0_ignore;
  logic [5:0] syndrome;
  int total = 0, bad = 0;
  logic [63:0] word;

  always #4 clk = ~clk;

  fgt_wtrap u_fgt_wtrap (.*);

  function automatic bit grp_both(int s);
    return s == 22 || s == 21 || s == 14 || s == 13 || s == 11 ||
           s == 10 || s == 9 || s == 8 || s == 3 || s == 2;
  endfunction
  function automatic bit grp_el1(int s);
    return s == 20 || s == 19 || s == 16 || s == 15 || s == 12 ||
           s == 7 || s == 5 || s == 4 || s == 1 || s == 0;
  endfunction
  function automatic bit exp_trap(logic [63:0] w, bit rq, int el, bit hy, int hm, int s);
    bit impl = grp_both(s) || grp_el1(s);
    if (!rq || !hy || !impl || w[s]) return 0;
    if (grp_both(s)) return (el <= 1) && (hm != 3);
    return el == 1;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (sel=%0d el=%0d hyp=%0b host=%0d req=%0b)",
               req, act, exp, wr_sel, wr_el, hyp_en, host_mode, wr_req);
    end
  endtask

  task automatic load(logic [63:0] w);
    @(negedge clk); ctl_we = 1; ctl_wdata = w;
    @(negedge clk); ctl_we = 0;
    word = w & 64'h79FFBF;
  endtask

  task automatic sweep(bit rq);
    for (int s = 0; s < 32; s++)
      for (int el = 0; el < 4; el++)
        for (int hy = 0; hy < 2; hy++)
          for (int hm = 0; hm < 4; hm++) begin
            bit et, ef;
            wr_req = rq; wr_sel = 5'(s); wr_el = 2'(el); hyp_en = hy[0]; host_mode = 2'(hm);
            #1;
            et = exp_trap(word, rq, el, hy[0], hm, s);
            // R3 R4 R5 R6 R7 R9 R11: trap decision
            check("R3/R4/R5/R6/R7/R9/R11 trap", {63'd0, trap}, {63'd0, et});
            check("R8 syndrome", {58'd0, syndrome}, et ? 64'h18 : 64'h0);
            ef = hy[0] && el <= 1 && hm != 3 && !word[2];
            check("R10 f0_ignore", {63'd0, f0_ignore}, {63'd0, ef});
          end
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset word", ctl_rdata, 64'h0);
    word = '0;
    sweep(1); sweep(0);
    load('1);
    check("R2 reserved masked", ctl_rdata, 64'h79FFBF);
    sweep(1);
    load(64'hA5A5_5A5A_0F0F_3C3C);
    check("R2 pattern", ctl_rdata, 64'hA5A5_5A5A_0F0F_3C3C & 64'h79FFBF);
    sweep(1);
    load(64'h0000_0000_0012_6949);
    sweep(1);

    // R12: write and request in the same cycle
    load('0);
    @(negedge clk);
    wr_req = 1; hyp_en = 1; host_mode = 0; wr_el = 1; wr_sel = 5'd13;
    ctl_we = 1; ctl_wdata = 64'h2000;
    #1 check("R12 old word before edge", {63'd0, trap}, 64'd1);
    @(posedge clk); #1;
    ctl_we = 0;
    check("R12 new word after edge", {63'd0, trap}, 64'd0);
    check("R12 stored", ctl_rdata, 64'h2000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule